// File: doc/BRIEF.md
# Speculative Store Buffer

This block sits between a core's store execution path and its data cache. Each executed store places its address, its data and its program-order tag into the buffer. It does not write the cache, so a store that is still speculative is never visible outside the core. Because stores only write the buffer, execution does not wait for a cache line to become writable. Execution can keep allocating while older stores wait for their line.

A retire pulse moves the oldest speculative entry into the graduated phase. For the oldest graduated entry, the buffer raises an ownership request carrying the entry's line address. The entry drains to the cache in the cycle that a grant for that same line arrives. On a mispredict or a fault, a squash carrying a program-order tag removes every speculative entry younger than that tag. Graduated entries are never removed.

Top module: `spec_store_buf`

## Requirements
- R1: While no entry is graduated, `own_req` and `cwr_vld` stay low, even with a grant present on the ownership inputs.
- R2: A `retire` pulse graduates the oldest speculative entry, with effect from the next cycle. A pulse while no speculative entry exists has no effect.
- R3: While a graduated entry exists, `own_req` is high and `own_line` carries bits [AW-1:LOFF] of the oldest graduated entry's address. That entry writes the cache (`cwr_vld`, `cwr_addr`, `cwr_data`) only in a cycle where `own_gnt` is high and `own_gnt_line` equals `own_line`. It leaves the buffer at the end of that cycle.
- R4: Cache writes occur strictly in allocation order, at most one per cycle. Back-to-back matching grants drain consecutive entries without skipping any.
- R5: An allocation is accepted when `alloc_vld` and `alloc_rdy` are both high. `alloc_rdy` is low when DEPTH entries (8 by default) are held, and a store offered then is lost.
- R6: `squash` removes every speculative entry whose tag is younger than `squash_tag`. A tag counts as younger when (tag − squash_tag) mod 2^TW is nonzero and has its top bit clear. Entries with an equal or older tag are kept.
- R7: A squash never removes a graduated entry, whatever its tag.
- R8: An allocation offered in a squash cycle is ignored.
- R9: A `retire` in the same cycle as `squash` takes effect first. The entry it graduates survives the squash.
- R10: While graduated entries wait for a grant, `alloc_rdy` stays high as long as space remains, and new stores are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | New store offered |
| alloc_addr | input | AW | Store address |
| alloc_data | input | DW | Store data |
| alloc_tag | input | TW | Program-order tag of the store |
| alloc_rdy | output | 1 | Buffer can accept a store |
| retire | input | 1 | Oldest speculative store has retired |
| squash | input | 1 | Discard younger speculative stores |
| squash_tag | input | TW | Tag of the squash point |
| own_req | output | 1 | Ownership requested for the oldest graduated line |
| own_line | output | AW-LOFF | Line address of the request |
| own_gnt | input | 1 | Ownership granted |
| own_gnt_line | input | AW-LOFF | Line address the grant refers to |
| cwr_vld | output | 1 | Cache write this cycle |
| cwr_addr | output | AW | Cache write address |
| cwr_data | output | DW | Cache write data |

## Verification
The bench offers a grant for the wrong line. A design that committed on any grant would write the cache there. It squashes at a tag that sits just before the wrap of the tag space. A plain magnitude compare would keep the store tagged 0 and drop nothing. It issues a squash older than already-graduated entries, and a squash in the same cycle as a retire. A design that scanned the whole buffer, or that applied the squash before the retire, would lose stores that have committed architecturally. It also fills the buffer and offers a ninth store, and allocates during a squash. A design with a wrong full limit or a wrong squash priority would later drain an extra store.

// File: rtl/sb_pkg.sv
package sb_pkg;
   // Tag ordering on a wrapping tag space of tw bits.
   function automatic logic tag_younger(input logic [31:0] tag, input logic [31:0] ref_t,
                                        input int tw);
      logic [31:0] diff;
      logic [31:0] mask;
      mask = (32'h1 << tw) - 32'h1;
      diff = (tag - ref_t) & mask;
      return (diff != 32'h0) && !diff[tw-1];
   endfunction
endpackage

// File: rtl/sb_store_ram.sv
module sb_store_ram #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TW    = 6
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [$clog2(DEPTH)-1:0]   wptr,
   input  logic [AW-1:0]              waddr,
   input  logic [DW-1:0]              wdata,
   input  logic [TW-1:0]              wtag,
   input  logic [$clog2(DEPTH)-1:0]   rptr,
   output logic [AW-1:0]              rd_addr,
   output logic [DW-1:0]              rd_data,
   output logic [DEPTH*TW-1:0]        tags
);
   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [TW-1:0] tag_q  [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         addr_q[wptr] <= waddr;
         data_q[wptr] <= wdata;
         tag_q[wptr]  <= wtag;
      end
   end

   assign rd_addr = addr_q[rptr];
   assign rd_data = data_q[rptr];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_tag
         assign tags[g*TW +: TW] = tag_q[g];
      end
   endgenerate
endmodule

// File: rtl/sb_squash_keep.sv
module sb_squash_keep
   import sb_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int TW    = 6
) (
   input  logic [DEPTH*TW-1:0]          tags,
   input  logic [$clog2(DEPTH)-1:0]     start,
   input  logic [$clog2(DEPTH+1)-1:0]   span,
   input  logic [TW-1:0]                ref_tag,
   output logic [$clog2(DEPTH+1)-1:0]   keep
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [PW-1:0] slot;
   logic [TW-1:0] etag;

   // Entries are tagged in program order, so the survivors form a prefix
   // of the speculative region: counting them gives the new tail.
   always_comb begin
      keep = '0;
      slot = '0;
      etag = '0;
      for (int i = 0; i < DEPTH; i++) begin
         slot = start + PW'(i);
         etag = tags[slot*TW +: TW];
         if ((CW'(i) < span) && !tag_younger(32'(etag), 32'(ref_tag), TW))
            keep = keep + CW'(1);
      end
   end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TW    = 6,
   parameter int LOFF  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               alloc_vld,
   input  logic [AW-1:0]      alloc_addr,
   input  logic [DW-1:0]      alloc_data,
   input  logic [TW-1:0]      alloc_tag,
   output logic               alloc_rdy,
   input  logic               retire,
   input  logic               squash,
   input  logic [TW-1:0]      squash_tag,
   output logic               own_req,
   output logic [AW-LOFF-1:0] own_line,
   input  logic               own_gnt,
   input  logic [AW-LOFF-1:0] own_gnt_line,
   output logic               cwr_vld,
   output logic [AW-1:0]      cwr_addr,
   output logic [DW-1:0]      cwr_data
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("spec_store_buf: DEPTH must be a power of two, at least 2");
      end
      if (TW < 2 || TW > 31) begin : g_bad_tw
         $error("spec_store_buf: TW must lie in 2..31");
      end
      if (LOFF < 0 || LOFF >= AW) begin : g_bad_loff
         $error("spec_store_buf: LOFF must lie below AW");
      end
   endgenerate

   logic [PW-1:0] head_q;
   logic [CW-1:0] cnt_q, gcnt_q;

   logic [CW-1:0] spec, spec_aft, spec_n, gcnt_n, cnt_n, keep;
   logic          pop, ret_ok, acc;
   logic [PW-1:0] tail, sq_start, head_n;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] head_data;
   logic [DEPTH*TW-1:0] tags;

   assign spec      = cnt_q - gcnt_q;
   assign alloc_rdy = (cnt_q < CW'(DEPTH));
   assign own_req   = (gcnt_q != '0);
   assign own_line  = head_addr[AW-1:LOFF];
   assign pop       = own_req && own_gnt && (own_gnt_line == own_line);
   assign cwr_vld   = pop;
   assign cwr_addr  = head_addr;
   assign cwr_data  = head_data;

   assign ret_ok   = retire && (spec != '0);
   assign acc      = alloc_vld && alloc_rdy && !squash;
   assign spec_aft = spec - CW'(ret_ok);
   assign tail     = head_q + cnt_q[PW-1:0];
   assign sq_start = head_q + gcnt_q[PW-1:0] + PW'(ret_ok);

   assign gcnt_n = gcnt_q - CW'(pop) + CW'(ret_ok);
   assign spec_n = squash ? keep : (spec_aft + CW'(acc));
   assign cnt_n  = gcnt_n + spec_n;
   assign head_n = head_q + PW'(pop);

   sb_store_ram #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_ram (
      .clk     (clk),
      .we      (acc),
      .wptr    (tail),
      .waddr   (alloc_addr),
      .wdata   (alloc_data),
      .wtag    (alloc_tag),
      .rptr    (head_q),
      .rd_addr (head_addr),
      .rd_data (head_data),
      .tags    (tags)
   );

   sb_squash_keep #(.DEPTH(DEPTH), .TW(TW)) u_keep (
      .tags    (tags),
      .start   (sq_start),
      .span    (spec_aft),
      .ref_tag (squash_tag),
      .keep    (keep)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         cnt_q  <= '0;
         gcnt_q <= '0;
      end else begin
         head_q <= head_n;
         cnt_q  <= cnt_n;
         gcnt_q <= gcnt_n;
      end
   end
endmodule

// File: rtl/sb_check.sv
module sb_check #(
   parameter int DEPTH = 8,
   parameter int LW    = 26,
   parameter int CW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] cnt,
   input logic [CW-1:0] gcnt,
   input logic          retire,
   input logic          squash,
   input logic          own_gnt,
   input logic [LW-1:0] own_gnt_line,
   input logic [LW-1:0] own_line,
   input logic          cwr_vld
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)); // R5
   AST_GRAD_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
      gcnt <= cnt); // R2
   AST_SPEC_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (gcnt == '0) |-> !cwr_vld); // R1
   AST_COMMIT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      cwr_vld |-> (own_gnt && (own_gnt_line == own_line))); // R3
   AST_RETIRE_GRADUATES: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && (cnt > gcnt) && !cwr_vld) |=> (gcnt == $past(gcnt) + CW'(1))); // R2
   AST_GRAD_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> ((CW+1)'(gcnt) + (CW+1)'($past(cwr_vld)) >= (CW+1)'($past(gcnt)))); // R7
endmodule

bind spec_store_buf sb_check #(.DEPTH(DEPTH), .LW(AW-LOFF), .CW($clog2(DEPTH+1))) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnt          (cnt_q),
   .gcnt         (gcnt_q),
   .retire       (retire),
   .squash       (squash),
   .own_gnt      (own_gnt),
   .own_gnt_line (own_gnt_line),
   .own_line     (own_line),
   .cwr_vld      (cwr_vld)
);

// File: tb/sim_spec_store_buf.sv
`timescale 1ns/1ps
module sim_spec_store_buf;
   localparam int AW = 32, DW = 32, TW = 6, LOFF = 6, LW = AW - LOFF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_vld = 1'b0, retire = 1'b0, squash = 1'b0, own_gnt = 1'b0;
   logic [AW-1:0] alloc_addr = '0;
   logic [DW-1:0] alloc_data = '0;
   logic [TW-1:0] alloc_tag = '0, squash_tag = '0;
   logic [LW-1:0] own_gnt_line = '0;
   logic alloc_rdy, own_req, cwr_vld;
   logic [LW-1:0] own_line;
   logic [AW-1:0] cwr_addr;
   logic [DW-1:0] cwr_data;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spec_store_buf u0 (.*);

   function automatic logic [AW-1:0] A(input int n);
      return 32'h0001_0000 + 32'(n) * 32'd64;
   endfunction
   function automatic logic [DW-1:0] D(input int n);
      return 32'hC0DE_0000 + 32'(n);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic t_alloc(input int n, input int tag);
      @(negedge clk);
      alloc_vld = 1'b1; alloc_addr = A(n); alloc_data = D(n); alloc_tag = TW'(tag);
      @(posedge clk); #1;
      alloc_vld = 1'b0;
   endtask

   task automatic t_retire();
      @(negedge clk); retire = 1'b1;
      @(posedge clk); #1; retire = 1'b0;
   endtask

   task automatic t_squash(input int tag, input bit with_retire, input bit with_alloc, input int n);
      @(negedge clk);
      squash = 1'b1; squash_tag = TW'(tag); retire = with_retire;
      alloc_vld = with_alloc; alloc_addr = A(n); alloc_data = D(n); alloc_tag = TW'(tag + 1);
      @(posedge clk); #1;
      squash = 1'b0; retire = 1'b0; alloc_vld = 1'b0;
   endtask

   // Grant the line of entry n and expect it to be written this cycle.
   task automatic t_drain(input int n, input string req);
      @(negedge clk);
      own_gnt = 1'b1; own_gnt_line = A(n) >> LOFF;
      #1;
      chk(cwr_vld === 1'b1, req, 64'(cwr_vld), 64'd1);
      chk(cwr_addr === A(n), req, 64'(cwr_addr), 64'(A(n)));
      chk(cwr_data === D(n), req, 64'(cwr_data), 64'(D(n)));
      @(posedge clk); #1;
      own_gnt = 1'b0;
   endtask

   task automatic t_expect_empty_grad(input string req);
      @(negedge clk);
      chk(own_req === 1'b0, req, 64'(own_req), 64'd0);
   endtask

   task automatic sc_reset();
      @(negedge clk);
      chk(alloc_rdy === 1'b1, "R5 reset rdy", 64'(alloc_rdy), 64'd1);
      chk(own_req === 1'b0, "R1 reset req", 64'(own_req), 64'd0);
      chk(cwr_vld === 1'b0, "R1 reset wr", 64'(cwr_vld), 64'd0);
   endtask

   task automatic sc_hidden_and_grant();
      t_alloc(1, 1);
      @(negedge clk);
      own_gnt = 1'b1; own_gnt_line = A(1) >> LOFF; #1;
      chk(own_req === 1'b0, "R1 spec no req", 64'(own_req), 64'd0);
      chk(cwr_vld === 1'b0, "R1 spec no write", 64'(cwr_vld), 64'd0);
      @(posedge clk); #1; own_gnt = 1'b0;
      t_retire();
      @(negedge clk);
      chk(own_req === 1'b1, "R2 retire req", 64'(own_req), 64'd1);
      chk(own_line === LW'(A(1) >> LOFF), "R3 req line", 64'(own_line), 64'(A(1) >> LOFF));
      own_gnt = 1'b1; own_gnt_line = (A(1) >> LOFF) + 1; #1;
      chk(cwr_vld === 1'b0, "R3 wrong line", 64'(cwr_vld), 64'd0);
      @(posedge clk); #1; own_gnt = 1'b0;
      @(negedge clk);
      chk(own_req === 1'b1, "R3 still waiting", 64'(own_req), 64'd1);
      t_drain(1, "R3 matching grant");
      t_expect_empty_grad("R3 drained");
   endtask

   task automatic sc_order_and_nostall();
      t_alloc(2, 2);
      t_retire();
      // graduated entry 2 waits; allocation continues
      for (int i = 3; i < 6; i++) begin
         @(negedge clk);
         chk(alloc_rdy === 1'b1, "R10 rdy while waiting", 64'(alloc_rdy), 64'd1);
         t_alloc(i, i);
      end
      t_retire(); t_retire(); t_retire();
      for (int i = 2; i < 6; i++) t_drain(i, "R4 in order");
      t_expect_empty_grad("R4 empty");
   endtask

   task automatic sc_full();
      for (int i = 0; i < 8; i++) t_alloc(30 + i, 30 + i);
      @(negedge clk);
      chk(alloc_rdy === 1'b0, "R5 full", 64'(alloc_rdy), 64'd0);
      t_alloc(38, 38);
      for (int i = 0; i < 9; i++) t_retire();
      for (int i = 0; i < 8; i++) t_drain(30 + i, "R5 drain");
      t_expect_empty_grad("R5 ninth lost");
   endtask

   task automatic sc_squash_basic();
      for (int i = 10; i < 14; i++) t_alloc(i, i);
      t_retire();
      t_squash(11, 1'b0, 1'b0, 0);
      t_retire(); t_retire(); t_retire();
      t_drain(10, "R6 keep older");
      t_drain(11, "R6 keep equal");
      t_expect_empty_grad("R6 younger removed");
   endtask

   task automatic sc_squash_wrap();
      t_alloc(62, 62); t_alloc(63, 63); t_alloc(0, 0);
      t_squash(63, 1'b0, 1'b0, 0);
      t_retire(); t_retire(); t_retire();
      t_drain(62, "R6 wrap keep");
      t_drain(63, "R6 wrap keep equal");
      t_expect_empty_grad("R6 wrap tag 0 removed");
   endtask

   task automatic sc_grad_survives();
      t_alloc(20, 20); t_alloc(21, 21);
      t_retire(); t_retire();
      t_squash(5, 1'b0, 1'b1, 22);
      t_retire();
      t_drain(20, "R7 graduated kept");
      t_drain(21, "R7 graduated kept");
      t_expect_empty_grad("R8 alloc in squash ignored");
   endtask

   task automatic sc_retire_with_squash();
      t_alloc(40, 40); t_alloc(41, 41);
      t_squash(39, 1'b1, 1'b0, 0);
      t_retire();
      t_drain(40, "R9 retired entry survives");
      t_expect_empty_grad("R9 younger removed");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      sc_reset();
      sc_hidden_and_grant();
      sc_order_and_nostall();
      sc_full();
      sc_squash_basic();
      sc_squash_wrap();
      sc_grad_survives();
      sc_retire_with_squash();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule